// File: doc/BRIEF.md
# Signed 4-bit ALU with status flags

This block is a purely combinational arithmetic-logic unit. It takes two 4-bit operands and a 4-bit operation select, and it drives an 8-bit result together with four status flags. Operands are read as two's-complement values for addition, subtraction and multiplication. For logical shifts and rotates, operand `a` is the data and operand `b` is an unsigned count.

The select codes form a sparse map in which some codes are one-hot. Only multiplication uses the upper half of the result. Every other operation puts its answer in the low nibble and forces the upper nibble to zero. The zero and negative flags always describe the low nibble. The carry and overflow flags are meaningful only for addition and subtraction and read zero otherwise. Any select code that is not in the map gives a zero result.

Top module: `alu4_flags`

## Requirements
- R1: With `op`=4'b0001, `y[3:0]` is (a+b) mod 16. `cf` is the carry out of bit 3 of the unsigned sum. `ovf` is 1 when `a` and `b` have the same sign and `y[3]` differs from that sign.
- R2: With `op`=4'b0010, `y[3:0]` is (a-b) mod 16. `cf` is the carry out of bit 3 of a + ~b + 1. `ovf` is 1 when the signs of `a` and `b` differ and `y[3]` differs from `a[3]`.
- R3: With `op`=4'b0100, `y[7:0]` is the 8-bit two's-complement product of signed `a` and signed `b`.
- R4: With `op`=4'b1000, `y[3:0]` is `a` shifted right logically by unsigned `b` with zero fill. A count of 4 or more gives 0.
- R5: With `op`=4'b1100, `y[3:0]` is `a` shifted left by unsigned `b` with zero fill. A count of 4 or more gives 0.
- R6: With `op`=4'b1010, `y[3:0]` is `a` rotated right by (b mod 4) positions within 4 bits.
- R7: With `op`=4'b1001, `y[3:0]` is `a` rotated left by (b mod 4) positions within 4 bits.
- R8: For every select code, `zf` is 1 exactly when `y[3:0]`=0, and `nf` equals `y[3]`.
- R9: For multiply, shifts and rotates, `cf` and `ovf` are 0.
- R10: For every select code except 4'b0100, `y[7:4]` is 0.
- R11: Any other select code gives `y`=0, `cf`=0, `ovf`=0, `zf`=1 and `nf`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | First operand (signed for arithmetic, data for shifts and rotates) |
| b | input | 4 | Second operand (signed for arithmetic, count for shifts and rotates) |
| op | input | 4 | Operation select |
| y | output | 8 | Result; the upper nibble is used only by multiply |
| cf | output | 1 | Carry out of bit 3 (add and subtract only) |
| ovf | output | 1 | Signed overflow (add and subtract only) |
| zf | output | 1 | Low result nibble is zero |
| nf | output | 1 | Sign bit of the low result nibble |

## Verification
The block holds no state, so a fault in its internal logic shows up at the outputs as soon as the inputs settle, within the same cycle as the input change. The faults most likely to escape a spot check are a sign-extension slip in the product, an off-by-one in the shift limit, the wrong rotate direction, and a carry polarity error on subtraction. Each of these corrupts only a subset of operand pairs. For that reason all 256 operand pairs are applied under each listed code and compared against an independent model. Randomly chosen unmapped codes are also applied to confirm that they give the all-zero result.

// File: rtl/alu4_flags.sv
module alu4_flags #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [3:0]     op,
  output logic [2*W-1:0] y,
  output logic           cf,
  output logic           ovf,
  output logic           zf,
  output logic           nf
);
  localparam int PW = 2 * W;
  localparam int CW = $clog2(W);

  localparam logic [3:0] OP_ADD = 4'b0001;
  localparam logic [3:0] OP_SUB = 4'b0010;
  localparam logic [3:0] OP_MUL = 4'b0100;
  localparam logic [3:0] OP_SHR = 4'b1000;
  localparam logic [3:0] OP_SHL = 4'b1100;
  localparam logic [3:0] OP_ROR = 4'b1010;
  localparam logic [3:0] OP_ROL = 4'b1001;

  logic [W:0]           sum, dif;
  logic signed [PW-1:0] prod;
  logic [CW-1:0]        rc;
  logic [PW-1:0]        ror_w, rol_w;
  logic                 big;

  assign sum   = {1'b0, a} + {1'b0, b};
  assign dif   = {1'b0, a} + {1'b0, ~b} + (W+1)'(1);
  assign prod  = $signed(a) * $signed(b);
  assign rc    = b[CW-1:0];
  assign ror_w = {a, a} >> rc;
  assign rol_w = {a, a} << rc;
  assign big   = (b >= W[W-1:0]) || (W < 4 && b[W-1]);

  always_comb begin
    y   = '0;
    cf  = 1'b0;
    ovf = 1'b0;
    case (op)
      OP_ADD: begin
        y[W-1:0] = sum[W-1:0];
        cf       = sum[W];
        ovf      = (a[W-1] == b[W-1]) && (sum[W-1] != a[W-1]);
      end
      OP_SUB: begin
        y[W-1:0] = dif[W-1:0];
        cf       = dif[W];
        ovf      = (a[W-1] != b[W-1]) && (dif[W-1] != a[W-1]);
      end
      OP_MUL: y = prod;
      OP_SHR: y[W-1:0] = big ? '0 : (a >> b);
      OP_SHL: y[W-1:0] = big ? '0 : (a << b);
      OP_ROR: y[W-1:0] = ror_w[W-1:0];
      OP_ROL: y[W-1:0] = rol_w[PW-1:W];
      default: ;
    endcase
  end

  assign zf = (y[W-1:0] == '0);
  assign nf = y[W-1];

  always_comb begin
    if (op != OP_MUL)
      assert_hi_clear_R10: assert (y[PW-1:W] == '0);
    if (op != OP_ADD && op != OP_SUB)
      assert_no_arith_flags_R9: assert (!cf && !ovf);
    if (op == OP_ROR || op == OP_ROL)
      assert_rot_keeps_bits_R6: assert ($countones(y) == $countones(a));
    if ((op == OP_SHR || op == OP_SHL) && big)
      assert_shift_flush_R4: assert (y == '0);
    assert_flag_excl_R8: assert (!(zf && nf));
    if (op == OP_MUL && (a == '0 || b == '0))
      assert_mul_zero_R3: assert (y == '0);
  end
endmodule

// File: tb/tb_alu4_flags.sv
module tb_alu4_flags;
  logic       clk = 1'b0;
  logic [3:0] a, b, op;
  logic [7:0] y;
  logic       cf, ovf, zf, nf;
  int         total = 0;
  int         bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  alu4_flags dut (.a(a), .b(b), .op(op), .y(y), .cf(cf), .ovf(ovf), .zf(zf), .nf(nf));

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'b0001: return "R1";
      4'b0010: return "R2";
      4'b0100: return "R3";
      4'b1000: return "R4";
      4'b1100: return "R5";
      4'b1010: return "R6";
      4'b1001: return "R7";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [11:0] model(input logic [3:0] o, input logic [3:0] x, input logic [3:0] z);
    int sx, sz, p, n;
    logic [7:0] r;
    logic c, v;
    r = 8'h00; c = 1'b0; v = 1'b0;
    sx = x[3] ? int'(x) - 16 : int'(x);
    sz = z[3] ? int'(z) - 16 : int'(z);
    n  = int'(z);
    case (o)
      4'b0001: begin
        r[3:0] = 4'((sx + sz) & 15);
        c = ((int'(x) + int'(z)) >= 16);
        v = (sx + sz > 7) || (sx + sz < -8);
      end
      4'b0010: begin
        r[3:0] = 4'((sx - sz) & 15);
        c = ((int'(x) + (15 - int'(z)) + 1) >= 16);
        v = (sx - sz > 7) || (sx - sz < -8);
      end
      4'b0100: begin
        p = sx * sz;
        r = 8'(p & 255);
      end
      4'b1000: r[3:0] = (n >= 4) ? 4'h0 : 4'((int'(x) / (1 << n)) & 15);
      4'b1100: r[3:0] = (n >= 4) ? 4'h0 : 4'((int'(x) * (1 << n)) & 15);
      4'b1010: for (int i = 0; i < 4; i++) r[i] = x[(i + n) % 4];
      4'b1001: for (int i = 0; i < 4; i++) r[(i + n) % 4] = x[i];
      default: r = 8'h00;
    endcase
    return {r, c, v, (r[3:0] == 4'h0), r[3]};
  endfunction

  task automatic chk(input string t, input string what, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s op=%b a=%h b=%h got=%h exp=%h", t, what, op, a, b, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [3:0] x, input logic [3:0] z);
    logic [11:0] e;
    string t;
    @(negedge clk);
    op = o; a = x; b = z;
    #1;
    e = model(o, x, z);
    t = tag_of(o);
    chk(t, "y_lo", {4'h0, y[3:0]}, {4'h0, e[7:4]});
    chk((o == 4'b0100) ? "R3" : "R10", "y_hi", {4'h0, y[7:4]}, {4'h0, e[11:8]});
    chk((o == 4'b0001 || o == 4'b0010) ? t : ((t == "R11") ? "R11" : "R9"), "cf_ovf", {6'h0, cf, ovf}, {6'h0, e[3:2]});
    chk("R8", "zf_nf", {6'h0, zf, nf}, {6'h0, e[1:0]});
  endtask

  initial begin
    logic [3:0] ops [7] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b1100, 4'b1010, 4'b1001};
    logic [3:0] r;
    int k;
    void'($urandom(32'd1234));
    op = 4'b0000; a = 4'h0; b = 4'h0;
    #1;
    chk("R11", "idle_y", y, 8'h00);
    chk("R11", "idle_flags", {4'h0, cf, ovf, zf, nf}, 8'h02);
    apply(4'b0100, 4'h8, 4'h8);
    chk("R3", "min_sq", y, 8'h40);
    apply(4'b0001, 4'h7, 4'h1);
    chk("R1", "pos_ovf", {7'h0, ovf}, 8'h01);
    apply(4'b0010, 4'h8, 4'h1);
    chk("R2", "neg_ovf", {7'h0, ovf}, 8'h01);
    apply(4'b1000, 4'hF, 4'h4);
    chk("R4", "count4", y, 8'h00);
    apply(4'b1001, 4'h1, 4'h5);
    chk("R7", "mod4", y, 8'h02);
    foreach (ops[i])
      for (int x = 0; x < 16; x++)
        for (int z = 0; z < 16; z++)
          apply(ops[i], 4'(x), 4'(z));
    k = 0;
    while (k < 40) begin
      r = 4'($urandom);
      if (r != 4'b0001 && r != 4'b0010 && r != 4'b0100 && r != 4'b1000 &&
          r != 4'b1100 && r != 4'b1010 && r != 4'b1001) begin
        apply(r, 4'($urandom), 4'($urandom));
        k++;
      end
    end
    for (int i = 0; i < 60; i++)
      apply(ops[$urandom % 7], 4'($urandom), 4'($urandom));
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule